// File: doc/BRIEF.md
# Addressed Multi-Drop Serial Receiver

This block receives asynchronous serial characters on a line shared by several stations. Each character has a ninth bit after its eight data bits. When that bit is 1, the character names a station. When it is 0, the character is payload. The receiver oversamples the line with a 16x tick and rebuilds each character. It then decides whether the character concerns this station.

After reset the receiver is not selected, and it drops every payload character. A character with the ninth bit set is compared with the `station_id` input. The result is reported as a one-cycle strobe with a match flag. A match selects the station, and the payload characters that follow appear on `rx_data` with a one-cycle `rx_valid`. A mismatch deselects the station until the next station character arrives.

Top module: `mp_uart_rx`

## Requirements
- R1: A character is a low start bit, 8 data bits with the LSB first, one kind bit, and a high stop bit. Each bit lasts 16 `baud_tick` pulses and is sampled near its middle.
- R2: If the line is no longer low at the middle of the start bit, the falling edge is dropped and produces no output pulse.
- R3: While `rst` is high and in the first cycle after it, the station is not selected and `rx_valid`, `id_strobe`, `id_match` and `framing_err` are 0.
- R4: A character with kind bit 0 that arrives while the station is not selected produces no `rx_valid`.
- R5: A character with kind bit 1 and a high stop bit raises `id_strobe` for one cycle. In that cycle `id_match` is 1 exactly when its data equals `station_id`.
- R6: After a match, each payload character with a high stop bit raises `rx_valid` for one cycle. In that cycle `rx_data` holds the character's byte.
- R7: After a mismatch, payload characters produce no `rx_valid` until a later station character matches.
- R8: A station character never raises `rx_valid`.
- R9: A stop bit sampled low raises `framing_err` for one cycle. The character is then neither delivered nor compared, and the selection state stays as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line, idle high |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| station_id | input | 8 | This station's address |
| rx_data | output | 8 | Delivered payload byte |
| rx_valid | output | 1 | One-cycle pulse marking `rx_data` |
| id_strobe | output | 1 | One-cycle pulse after each station character |
| id_match | output | 1 | Address comparison result, qualified by `id_strobe` |
| framing_err | output | 1 | One-cycle pulse when a stop bit is sampled low |

## Verification
The checker watches the local rules on every cycle:
- Each output pulse lasts a single cycle.
- No two kinds of result fire together.
- `id_match` appears only with `id_strobe`.
- The selection flag follows every comparison.
- Delivery happens only while the station is selected.

Other behaviour needs the bench's scenarios:
- Sampling the bits in the right order.
- Rejecting a glitch on the start bit.
- Comparing against a `station_id` that changes.
- Keeping the selection state across a framing error.

In those scenarios a behavioural model predicts every pulse and value.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned OSR    = 16;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_KIND,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              kind;
        logic              stop_ok;
    } char_t;

    function automatic logic id_equal(input logic [DATA_W-1:0] a,
                                      input logic [DATA_W-1:0] b);
        return a == b;
    endfunction
endpackage

// File: rtl/mpr_sync.sv
module mpr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/mpr_framer.sv
module mpr_framer
    import mpr_pkg::*;
#(
    parameter int unsigned DW  = DATA_W,
    parameter int unsigned OVS = OSR
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  line,
    input  logic  tick,
    output logic  char_vld,
    output char_t char_q
);
    localparam int unsigned CNT_W = $clog2(OVS);
    localparam int unsigned IDX_W = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] TOP  = IDX_W'(DW - 1);

    rx_state_e        state;
    logic [CNT_W-1:0] tcnt;
    logic [IDX_W-1:0] bidx;
    logic [DW-1:0]    shreg;
    logic             kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            tcnt     <= '0;
            bidx     <= '0;
            shreg    <= '0;
            kind_q   <= 1'b0;
            char_vld <= 1'b0;
            char_q   <= '0;
        end else begin
            char_vld <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: begin
                        tcnt <= '0;
                        if (!line) state <= RX_START;
                    end
                    RX_START: begin
                        if (tcnt == MID) begin
                            tcnt <= '0;
                            bidx <= '0;
                            state <= line ? RX_IDLE : RX_DATA;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (tcnt == LAST) begin
                            tcnt  <= '0;
                            shreg <= {line, shreg[DW-1:1]};
                            if (bidx == TOP) state <= RX_KIND;
                            else             bidx  <= bidx + 1'b1;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_KIND: begin
                        if (tcnt == LAST) begin
                            tcnt   <= '0;
                            kind_q <= line;
                            state  <= RX_STOP;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (tcnt == LAST) begin
                            tcnt           <= '0;
                            char_vld       <= 1'b1;
                            char_q.data    <= shreg;
                            char_q.kind    <= kind_q;
                            char_q.stop_ok <= line;
                            state          <= RX_IDLE;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mpr_filter.sv
module mpr_filter
    import mpr_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          char_vld,
    input  char_t         char_q,
    input  logic [DW-1:0] my_id,
    output logic [DW-1:0] out_data,
    output logic          out_vld,
    output logic          cmp_stb,
    output logic          cmp_hit,
    output logic          frm_err,
    output logic          selected
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_data <= '0;
            out_vld  <= 1'b0;
            cmp_stb  <= 1'b0;
            cmp_hit  <= 1'b0;
            frm_err  <= 1'b0;
            selected <= 1'b0;
        end else begin
            out_vld <= 1'b0;
            cmp_stb <= 1'b0;
            cmp_hit <= 1'b0;
            frm_err <= 1'b0;
            if (char_vld) begin
                if (!char_q.stop_ok) begin
                    frm_err <= 1'b1;
                end else if (char_q.kind) begin
                    cmp_stb  <= 1'b1;
                    cmp_hit  <= id_equal(char_q.data, my_id);
                    selected <= id_equal(char_q.data, my_id);
                end else if (selected) begin
                    out_vld  <= 1'b1;
                    out_data <= char_q.data;
                end
            end
        end
    end
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
    import mpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rxd,
    input  logic              baud_tick,
    input  logic [DATA_W-1:0] station_id,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              id_strobe,
    output logic              id_match,
    output logic              framing_err
);
    logic  line_s;
    logic  char_vld;
    char_t char_q;
    logic  sel;

    mpr_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (line_s)
    );

    mpr_framer #(.DW(DATA_W), .OVS(OSR)) u_framer (
        .clk      (clk),
        .rst      (rst),
        .line     (line_s),
        .tick     (baud_tick),
        .char_vld (char_vld),
        .char_q   (char_q)
    );

    mpr_filter #(.DW(DATA_W)) u_filter (
        .clk      (clk),
        .rst      (rst),
        .char_vld (char_vld),
        .char_q   (char_q),
        .my_id    (station_id),
        .out_data (rx_data),
        .out_vld  (rx_valid),
        .cmp_stb  (id_strobe),
        .cmp_hit  (id_match),
        .frm_err  (framing_err),
        .selected (sel)
    );
endmodule

// File: rtl/mp_uart_rx_chk.sv
module mp_uart_rx_chk (
    input logic clk,
    input logic rst,
    input logic rx_valid,
    input logic id_strobe,
    input logic id_match,
    input logic framing_err,
    input logic sel
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R6
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        id_strobe |=> !id_strobe); // R5
    AST_FERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        framing_err |=> !framing_err); // R9
    AST_FERR_ALONE: assert property (@(posedge clk) disable iff (rst)
        framing_err |-> !rx_valid && !id_strobe); // R9
    AST_ID_NOT_DATA: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_valid, id_strobe})); // R8
    AST_MATCH_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        id_match |-> id_strobe); // R5
    AST_SEL_FOLLOWS_CMP: assert property (@(posedge clk) disable iff (rst)
        id_strobe |-> sel == id_match); // R7
    AST_DELIVER_SELECTED: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> sel); // R4
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !sel && !rx_valid && !id_strobe && !framing_err); // R3
    AST_FERR_KEEPS_SEL: assert property (@(posedge clk) disable iff (rst)
        framing_err |-> $stable(sel)); // R9
endmodule

bind mp_uart_rx mp_uart_rx_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_valid    (rx_valid),
    .id_strobe   (id_strobe),
    .id_match    (id_match),
    .framing_err (framing_err),
    .sel         (sel)
);

// File: tb/mp_uart_rx_tb.sv
`timescale 1ns/1ps
module mp_uart_rx_tb;
    localparam int TICK_DIV = 2;
    localparam int BIT_CYC  = 16 * TICK_DIV;
    localparam int GAP_CYC  = 48;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic       baud_tick = 1'b0;
    logic [7:0] station_id = 8'h01;
    logic [7:0] rx_data;
    logic       rx_valid, id_strobe, id_match, framing_err;

    int checks = 0;
    int errors = 0;
    int tdiv = 0;

    logic [7:0] data_q[$];
    bit         id_q[$];
    int         ferr_exp = 0;
    bit         m_sel = 0;
    bit         pv_valid = 0, pv_strobe = 0, pv_ferr = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (tdiv == TICK_DIV - 1) begin tdiv <= 0; baud_tick <= 1'b1; end
        else begin tdiv <= tdiv + 1; baud_tick <= 1'b0; end
    end

    mp_uart_rx u_dut (
        .clk(clk), .rst(rst), .rxd(rxd), .baud_tick(baud_tick),
        .station_id(station_id), .rx_data(rx_data), .rx_valid(rx_valid),
        .id_strobe(id_strobe), .id_match(id_match), .framing_err(framing_err)
    );

    // Per-cycle comparison against the behavioural model
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                checks++;
                if (data_q.size() == 0) begin
                    errors++;
                    $display("FAIL R4/R6/R7/R8: rx_valid data=%h, expected no delivery", rx_data);
                end else begin
                    if (rx_data !== data_q[0]) begin
                        errors++;
                        $display("FAIL R6: rx_data=%h expected %h", rx_data, data_q[0]);
                    end
                    void'(data_q.pop_front());
                end
            end
            if (id_strobe) begin
                checks++;
                if (id_q.size() == 0) begin
                    errors++;
                    $display("FAIL R5/R9: id_strobe=1 expected 0");
                end else begin
                    if (id_match !== id_q[0]) begin
                        errors++;
                        $display("FAIL R5: id_match=%b expected %b", id_match, id_q[0]);
                    end
                    void'(id_q.pop_front());
                end
            end else if (id_match) begin
                checks++; errors++;
                $display("FAIL R5: id_match=1 without strobe, expected 0");
            end
            if (framing_err) begin
                checks++;
                if (ferr_exp == 0) begin
                    errors++;
                    $display("FAIL R9: framing_err=1 expected 0");
                end else ferr_exp--;
            end
            if ((rx_valid && pv_valid) || (id_strobe && pv_strobe) || (framing_err && pv_ferr)) begin
                checks++; errors++;
                $display("FAIL R5/R6/R9: pulse longer than one cycle, got 2 expected 1");
            end
            pv_valid  = rx_valid;
            pv_strobe = id_strobe;
            pv_ferr   = framing_err;
        end
    end

    task automatic drive_bit(input logic b);
        rxd = b;
        repeat (BIT_CYC) @(posedge clk);
    endtask

    task automatic check_drained(input string req);
        checks++;
        if (data_q.size() != 0 || id_q.size() != 0 || ferr_exp != 0) begin
            errors++;
            $display("FAIL %s: pending data=%0d id=%0d ferr=%0d, expected 0 0 0",
                     req, data_q.size(), id_q.size(), ferr_exp);
        end
    endtask

    task automatic send_char(input logic [7:0] d, input logic kind, input logic stopb,
                             input string req);
        if (!stopb) ferr_exp++;
        else if (kind) begin
            id_q.push_back(d == station_id);
            m_sel = (d == station_id);
        end else if (m_sel) data_q.push_back(d);
        @(posedge clk); #1;
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(d[i]);
        drive_bit(kind);
        drive_bit(stopb);
        rxd = 1'b1;
        repeat (GAP_CYC) @(posedge clk);
        check_drained(req);
    endtask

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog: run still busy, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        checks++;
        if (rx_valid || id_strobe || id_match || framing_err) begin
            errors++;
            $display("FAIL R3: outputs %b%b%b%b during reset, expected 0000",
                     rx_valid, id_strobe, id_match, framing_err);
        end
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        checks++;
        if (rx_valid || id_strobe || id_match || framing_err) begin
            errors++;
            $display("FAIL R3: outputs %b%b%b%b after reset, expected 0000",
                     rx_valid, id_strobe, id_match, framing_err);
        end
        repeat (20) @(posedge clk);

        send_char(8'h55, 1'b0, 1'b1, "R4");   // unselected payload dropped
        send_char(8'h02, 1'b1, 1'b1, "R5");   // mismatch
        send_char(8'h66, 1'b0, 1'b1, "R7");
        send_char(8'h01, 1'b1, 1'b1, "R5");   // match
        send_char(8'hAA, 1'b0, 1'b1, "R6");
        send_char(8'h3C, 1'b0, 1'b1, "R1");   // bit order
        send_char(8'h01, 1'b1, 1'b1, "R8");   // station char, no data
        // R2: short low pulse shorter than half a bit
        @(posedge clk); #1 rxd = 1'b0;
        repeat (6) @(posedge clk);
        #1 rxd = 1'b1;
        repeat (600) @(posedge clk);
        check_drained("R2");
        send_char(8'h99, 1'b0, 1'b0, "R9");   // bad stop, not delivered
        send_char(8'h81, 1'b0, 1'b1, "R9");   // still selected
        send_char(8'h03, 1'b1, 1'b1, "R7");   // mismatch
        send_char(8'h7E, 1'b0, 1'b1, "R7");
        send_char(8'h01, 1'b1, 1'b0, "R9");   // bad-stop station char, not compared
        send_char(8'h24, 1'b0, 1'b1, "R9");
        station_id = 8'h42;
        send_char(8'h42, 1'b1, 1'b1, "R5");
        for (int k = 0; k < 4; k++)
            send_char(8'(k * 37 + 5), 1'b0, 1'b1, "R6");
        send_char(8'hFF, 1'b0, 1'b1, "R1");
        send_char(8'h00, 1'b0, 1'b1, "R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule